// File: doc/BRIEF.md
# Registered ROM with Configurable Address Capture

This block is a read-only word store with a pipelined output. On each rising clock edge the word at the internal address moves into an output register. The output is modelled as a data bus plus a valid flag: the flag low stands for a high-impedance bus, and the data then reads as zero. A simulation load port fills the array and a three-bit configuration byte.

The configuration byte makes three choices. It sets whether the output enable gates the register combinationally or is sampled by the clock. It sets whether the address passes straight through or is captured under a latch-enable input. It also sets the active level of that latch enable. The array depth is `2**ADDR_W` words. `ADDR_W = 15` gives the full 32K-word part, and the default is smaller so the array stays cheap to elaborate.

Top module: `regrom_core`

## Requirements
- R1: A cycle with `load_en` high and `load_addr[ADDR_W]` = 0 writes `load_data` to word `load_addr[ADDR_W-1:0]`. A read of that word in a later cycle returns the new value.
- R2: At each rising `clk` edge the output register captures the word at the internal address, and that word appears on `out_data` after the edge.
- R3: Configuration bit 0 selects the enable mode: 0 means combinational enable and 1 means clock-sampled enable. After reset the bit is 0.
- R4: In combinational mode, `oe_n` low makes `out_valid` 1 and `oe_n` high makes it 0 at once, with no clock edge needed.
- R5: In clock-sampled mode, `out_valid` equals the inverse of `oe_n` as sampled at the most recent rising edge. A change of `oe_n` between edges has no effect until the next edge.
- R6: When configuration bit 1 is 0, the internal address equals `addr` and `ale` is ignored. When bit 1 is 1, the internal address follows `addr` while `ale` is active. While `ale` is inactive it holds the `addr` value sampled at the last rising edge on which `ale` was active.
- R7: Configuration bit 2 sets the active level of `ale`: 0 means active high and 1 means active low.
- R8: A load to address `2**ADDR_W` writes configuration bits [2:0] from `load_data[2:0]`, and `load_data` bits above 2 are ignored. A load to any other address with `load_addr[ADDR_W]` = 1 changes nothing.
- R9: Reset clears the configuration to all zeros, sets the sampled enable to disabled, and clears the output register to zero.
- R10: Whenever `out_valid` is 0, `out_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Read address |
| ale | input | 1 | Address latch enable, active level set by configuration |
| oe_n | input | 1 | Output enable, active low |
| load_en | input | 1 | Load strobe |
| load_addr | input | ADDR_W+1 | Load address; MSB set selects the configuration space |
| load_data | input | WORD_W | Load data |
| out_data | output | WORD_W | Registered word, zero when not valid |
| out_valid | output | 1 | 1 = bus driven, 0 = high impedance |

## Verification
A wrong held address in latched mode shows up on `out_data` one edge after `ale` goes inactive, as a word taken from the wrong location. A stale sampled enable shows up as a wrong `out_valid` right after an edge. A wrong combinational gate shows up between edges within the same cycle. The bench flips `oe_n` mid-cycle and checks before the next edge, so it separates the two enable modes inside a single cycle. It repeats the address sequence under all eight configurations, so a wrong decode of any configuration bit fails within one pass.

// File: rtl/regrom_pkg.sv
package regrom_pkg;

   // Bit positions inside the configuration byte (decoded by regrom_store).
   localparam int CFG_OE_SYNC_BIT = 0;
   localparam int CFG_LATCH_BIT   = 1;
   localparam int CFG_POL_LOW_BIT = 2;
   localparam int CFG_BITS        = 3;

   typedef struct packed {
      logic ale_low;     // latch enable active low
      logic latched;     // address captured under ale
      logic oe_sync;     // output enable sampled by clk
   } arch_cfg_t;

   function automatic arch_cfg_t decode_arch(input logic [CFG_BITS-1:0] raw);
      arch_cfg_t c;
      c.oe_sync = raw[CFG_OE_SYNC_BIT];
      c.latched = raw[CFG_LATCH_BIT];
      c.ale_low = raw[CFG_POL_LOW_BIT];
      return c;
   endfunction

endpackage

// File: rtl/regrom_store.sv
module regrom_store
   import regrom_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W:0]   load_addr,
   input  logic [WORD_W-1:0] load_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_word,
   output arch_cfg_t         cfg
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [ADDR_W:0] ARCH_ADDR = {1'b1, {ADDR_W{1'b0}}};

   logic [WORD_W-1:0] mem [DEPTH];
   logic              arch_hit;
   logic              data_hit;

   initial begin
      assert (WORD_W >= CFG_BITS) else $error("WORD_W must hold the configuration bits");
   end

   assign data_hit = load_en && !load_addr[ADDR_W];
   assign arch_hit = load_en && (load_addr == ARCH_ADDR);

   always_ff @(posedge clk) begin
      if (data_hit) mem[load_addr[ADDR_W-1:0]] <= load_data;
   end

   assign rd_word = mem[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg <= '0;
      else if (arch_hit) cfg <= decode_arch(load_data[CFG_BITS-1:0]);
   end

   // R8: configuration byte load takes only bits [2:0]
   p_arch_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      arch_hit |=> (cfg == decode_arch($past(load_data[CFG_BITS-1:0]))));
   // R8: nothing else moves the configuration
   p_arch_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !arch_hit |=> $stable(cfg));

endmodule

// File: rtl/regrom_addr_path.sv
module regrom_addr_path #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              ale,
   input  logic              latched,
   input  logic              ale_low,
   output logic [ADDR_W-1:0] addr_out
);
   logic              ale_act;
   logic [ADDR_W-1:0] hold_q;

   assign ale_act = ale ^ ale_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold_q <= '0;
      else if (ale_act) hold_q <= addr_in;
   end

   assign addr_out = (latched && !ale_act) ? hold_q : addr_in;

   // R6: in latched mode an inactive latch enable freezes the address
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && latched && $past(latched) && !ale_act && $past(!ale_act))
      |-> $stable(addr_out));

endmodule

// File: rtl/regrom_out_stage.sv
module regrom_out_stage #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] rd_word,
   input  logic              oe_n,
   input  logic              oe_sync,
   output logic [WORD_W-1:0] out_data,
   output logic              out_valid
);
   logic [WORD_W-1:0] reg_q;
   logic              en_q;   // sampled oe_n, 1 = disabled

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q <= '0;
         en_q  <= 1'b1;
      end else begin
         reg_q <= rd_word;
         en_q  <= oe_n;
      end
   end

   assign out_valid = oe_sync ? !en_q : !oe_n;

   for (genvar i = 0; i < WORD_W; i++) begin : g_gate
      assign out_data[i] = reg_q[i] & out_valid;
   end

   // R2: the register holds the word presented at the previous edge
   p_pipe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (reg_q == $past(rd_word)));
   // R4: combinational mode disables at once
   p_async_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_sync && oe_n) |-> !out_valid);
   // R5: sampled mode follows the enable seen at the last edge
   p_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_sync && $past(rst_n)) |-> (out_valid == !$past(oe_n)));
   // R10: an undriven bus reads zero
   p_off_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_data == '0));

endmodule

// File: rtl/regrom_core.sv
module regrom_core
   import regrom_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ale,
   input  logic              oe_n,
   input  logic              load_en,
   input  logic [ADDR_W:0]   load_addr,
   input  logic [WORD_W-1:0] load_data,
   output logic [WORD_W-1:0] out_data,
   output logic              out_valid
);
   arch_cfg_t         cfg;
   logic [ADDR_W-1:0] int_addr;
   logic [WORD_W-1:0] rd_word;

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 15) else $error("ADDR_W out of range");
   end

   regrom_addr_path #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .addr_in(addr), .ale(ale),
      .latched(cfg.latched), .ale_low(cfg.ale_low), .addr_out(int_addr));

   regrom_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
      .load_data(load_data), .rd_addr(int_addr), .rd_word(rd_word), .cfg(cfg));

   regrom_out_stage #(.WORD_W(WORD_W)) u_out (
      .clk(clk), .rst_n(rst_n), .rd_word(rd_word), .oe_n(oe_n),
      .oe_sync(cfg.oe_sync), .out_data(out_data), .out_valid(out_valid));

   // R6: with the transparent setting the array sees the pin address
   p_transp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.latched |-> (int_addr == addr));

endmodule

// File: tb/regrom_core_bench.sv
`timescale 1ns/1ps
module regrom_core_bench;
   localparam int AW = 11;
   localparam int DEPTH = 1 << AW;
   localparam logic [AW:0] ARCH = {1'b1, {AW{1'b0}}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic ale = 1'b0;
   logic oe_n = 1'b1;
   logic load_en = 1'b0;
   logic [AW:0] load_addr = '0;
   logic [7:0] load_data = '0;
   logic [7:0] out_data;
   logic out_valid;

   always #10 clk = ~clk;   // 50 MHz

   regrom_core #(.ADDR_W(AW), .WORD_W(8)) u_regrom_core (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ale(ale), .oe_n(oe_n),
      .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
      .out_data(out_data), .out_valid(out_valid));

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference model
   logic [7:0] rmem [DEPTH];
   logic [2:0] rcfg = '0;
   logic [AW-1:0] rhold = '0;
   logic ren_q = 1'b1;
   logic [7:0] rreg = '0;

   // scoreboard
   bit exp_v[$];
   logic [7:0] exp_d[$];
   string exp_t[$];

   task automatic chk(input bit v, input logic [7:0] d, input bit ev,
                      input logic [7:0] ed, input string tag);
      n_chk++;
      if (v !== ev || d !== ed) begin
         n_fail++;
         $display("FAIL %s: valid=%0b data=%02h expected valid=%0b data=%02h",
                  tag, v, d, ev, ed);
      end
   endtask

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 37) ^ (i >> 3) ^ 8'h5A);
   endfunction

   // Called at a falling edge; ends at the next falling edge.
   task automatic cycle(input logic [AW-1:0] a, input bit al, input bit oe,
                        input bit flip, input bit le, input logic [AW:0] la,
                        input logic [7:0] ld, input string tag);
      logic [AW-1:0] ia;
      bit act, ev;
      addr = a; ale = al; oe_n = oe; load_en = le; load_addr = la; load_data = ld;
      if (flip) begin
         #4 oe_n = ~oe;
         #2;
         ev = rcfg[0] ? !ren_q : !oe_n;
         chk(out_valid, out_data, ev, ev ? rreg : 8'h00, rcfg[0] ? "R5 mid-cycle" : "R4 mid-cycle");
      end
      @(posedge clk);
      act = ale ^ rcfg[2];
      ia = (rcfg[1] && !act) ? rhold : a;
      rreg = rmem[ia];
      if (act) rhold = a;
      ren_q = oe_n;
      if (le) begin
         if (!la[AW]) rmem[la[AW-1:0]] = ld;
         else if (la == ARCH) rcfg = ld[2:0];
      end
      ev = rcfg[0] ? !ren_q : !oe_n;
      exp_v.push_back(ev);
      exp_d.push_back(ev ? rreg : 8'h00);
      exp_t.push_back(ev ? tag : "R10 undriven");
      @(negedge clk);
   endtask

   // monitor
   always @(posedge clk) begin
      #5;
      if (exp_v.size() > 0)
         chk(out_valid, out_data, exp_v.pop_front(), exp_d.pop_front(), exp_t.pop_front());
   end

   initial begin
      #(20 * 60000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      bit a_act;
      for (int i = 0; i < DEPTH; i++) rmem[i] = 8'h00;
      #1 chk(out_valid, out_data, 1'b0, 8'h00, "R9 in reset");
      repeat (3) @(negedge clk);
      oe_n = 1'b0;
      #2 chk(out_valid, out_data, 1'b1, 8'h00, "R9 cleared register, default enable");
      @(negedge clk);
      rst_n = 1'b1;
      // fill array with outputs off (first edge reads an unwritten word)
      for (int i = 0; i < DEPTH; i++)
         cycle('0, 1'b0, 1'b1, 1'b0, 1'b1, (AW+1)'(i), pat(i), "R1 fill");
      cycle(12'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R1 R2 first read");
      for (int c = 0; c < 8; c++) begin
         a_act = !c[2];
         cycle(11'd5, 1'b0, 1'b0, 1'b0, 1'b1, ARCH, {5'b10101, 3'(c)}, "R8 R3 config load");
         cycle(11'd6, 1'b0, 1'b0, 1'b0, 1'b1, ARCH + 1, {5'b0, ~3'(c)}, "R8 ignored load");
         cycle(11'd10, a_act, 1'b0, 1'b0, 1'b0, '0, '0, "R2 R7 active ale");
         cycle(11'd20, a_act, 1'b0, 1'b0, 1'b0, '0, '0, "R2 R7 active ale");
         cycle(11'd30, !a_act, 1'b0, 1'b0, 1'b0, '0, '0, "R6 R7 ale inactive");
         cycle(11'd40, !a_act, 1'b0, 1'b1, 1'b0, '0, '0, "R4 R5 after flip");
         cycle(11'd50, !a_act, 1'b1, 1'b1, 1'b0, '0, '0, "R4 R5 after flip");
         cycle(11'd60, a_act, 1'b0, 1'b0, 1'b1, 12'd20, 8'(c * 3 + 1), "R1 R3 load during read");
         cycle(11'd20, a_act, 1'b0, 1'b0, 1'b0, '0, '0, "R1 reload visible");
         cycle(11'd70, !a_act, 1'b0, 1'b0, 1'b0, '0, '0, "R6 held address");
         cycle(11'd2047, !a_act, 1'b0, 1'b1, 1'b0, '0, '0, "R6 R4 R5 held address");
         cycle(11'd100, !a_act, 1'b1, 1'b0, 1'b0, '0, '0, "R10 disabled");
      end
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule